// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a small programmable device. It runs the standard sixteen-state TAP state machine on the test clock, using the mode-select and serial data inputs. It drives a serial data output together with an enable that says when the output pad should be driven. A 10-bit instruction register picks one data register to sit between serial in and serial out. The choices are a single-bit bypass stage, a 32-bit identification code, a 32-bit user code, a 16-bit signature word, and a boundary chain whose length is set by parameters.

Boundary cells are modelled as capture flops on abstract pin signals and update latches on the output pins. In normal operation the output pins carry the core's values. Under the external-test instruction they carry the contents of the update latches instead. The identification, user-code and signature values are fixed by parameters when the block is built. At the pins, the block is driven as a board-level test controller would drive any chain.

Top module: `jtag_tap_top`

## Requirements
- R1: With TMS held high for five rising TCK edges the controller reaches Test-Logic-Reset from any state. Test-Logic-Reset, and a low `trstN`, make IDCODE (opcode 10'h059) the active instruction.
- R2: `tdoEn` is high only while the controller is in Shift-IR or Shift-DR. `tdo` and `tdoEn` change on the falling edge of TCK.
- R3: In Capture-IR the instruction shifter loads 10'b00_0000_0001, so the first bit shifted out is 1 and the next nine are 0.
- R4: The instruction register is 10 bits, shifted LSB first and made active in Update-IR; otherwise it holds. The opcodes are EXTEST 10'h000, SAMPLE/PRELOAD 10'h055, IDCODE 10'h059, USERCODE 10'h007, SIGNATURE 10'h079 and BYPASS 10'h3FF. Every other opcode selects the bypass register.
- R5: The bypass register is one bit long, captures 0 and delays TDI by exactly one shift.
- R6: The identification register is 32 bits: version in [31:28], part number in [27:12], manufacturer identity in [11:1], and bit 0 always 1.
- R7: USERCODE selects a 32-bit register that captures the USER_CODE parameter.
- R8: SIGNATURE selects a 16-bit register that captures the SIG_CODE parameter.
- R9: Under SAMPLE/PRELOAD the boundary chain captures the input pins in bits [IN_PINS-1:0] and the core output values in the bits above them. The output pins keep following `coreOut`.
- R10: Under EXTEST each output pin is driven from its update latch and ignores `coreOut`. The chain captures the input pins in the same positions as in R9.
- R11: Every data register is loaded in Capture-DR and shifted LSB first in Shift-DR. The output-pin update latches change only in Update-DR while the boundary chain is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdoEn | output | 1 | High when the serial output pad should be driven |
| pinIn | input | IN_PINS | Values seen on the device input pins |
| coreOut | input | OUT_PINS | Values the core logic wants on the output pins |
| pinOut | output | OUT_PINS | Values sent to the output pin drivers |

## Verification
The hardest state to reach from the ports is an EXTEST session parked in Pause-DR. In that state a new pattern is half shifted into the chain while the pins must still show the old latch values. The bench first preloads a pattern under SAMPLE/PRELOAD, then switches the instruction to EXTEST and checks that the preloaded outputs appear on the pins. It then shifts a second pattern, leaves through Exit1-DR into Pause-DR and checks that the pins have not moved. Only after that does it finish through Update-DR and check the new values. The reset path is exercised by loading a non-default instruction and then clocking five TMS-high edges without the reset pin.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 10;

  localparam logic [IR_W-1:0] OP_EXTEST = 10'h000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 10'h055;
  localparam logic [IR_W-1:0] OP_IDCODE = 10'h059;
  localparam logic [IR_W-1:0] OP_USER   = 10'h007;
  localparam logic [IR_W-1:0] OP_SIG    = 10'h079;
  localparam logic [IR_W-1:0] OP_BYPASS = 10'h3FF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 10'b00_0000_0001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef enum logic [2:0] {
    DR_BYP, DR_ID, DR_USER, DR_SIG, DR_BSR
  } drSel_e;

  // strobes from the controller to the data registers
  typedef struct packed {
    logic capDr;
    logic shDr;
    logic updDr;
    logic shIr;
  } tapStrobe_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  input  logic       tdi,
  output tapStrobe_t strobe,
  output drSel_e     drSel,
  output logic       extestOn,
  output logic       irTdo
);

  tapState_e state, nextState;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_TLR:    nextState = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nextState = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_RTI;
      default:   nextState = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_TLR;
    else        state <= nextState;
  end

  // instruction shifter and active instruction
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      irReg   <= OP_IDCODE;
    end else begin
      if (state == ST_CAP_IR)      irShift <= IR_CAPTURE;
      else if (state == ST_SH_IR)  irShift <= {tdi, irShift[IR_W-1:1]};
      if (state == ST_TLR)         irReg <= OP_IDCODE;
      else if (state == ST_UPD_IR) irReg <= irShift;
    end
  end

  always_comb begin
    unique case (irReg)
      OP_EXTEST, OP_SAMPLE: drSel = DR_BSR;
      OP_IDCODE:            drSel = DR_ID;
      OP_USER:              drSel = DR_USER;
      OP_SIG:               drSel = DR_SIG;
      default:              drSel = DR_BYP;
    endcase
  end

  assign extestOn     = (irReg == OP_EXTEST);
  assign irTdo        = irShift[0];
  assign strobe.capDr = (state == ST_CAP_DR);
  assign strobe.shDr  = (state == ST_SH_DR);
  assign strobe.updDr = (state == ST_UPD_DR);
  assign strobe.shIr  = (state == ST_SH_IR);

  // run of consecutive TMS-high edges, saturating at five
  logic [2:0] tmsRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              tmsRun <= '0;
    else if (!tms)           tmsRun <= '0;
    else if (tmsRun != 3'd5) tmsRun <= tmsRun + 3'd1;
  end

  p_tms_reset_r1: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun == 3'd5) |-> (state == ST_TLR));

  p_tlr_idcode_r1: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_TLR) |=> (irReg == OP_IDCODE));

  p_ir_hold_r4: assert property (@(posedge tck) disable iff (!trstN)
    !(state == ST_UPD_IR || state == ST_TLR) |=> $stable(irReg));

endmodule

// File: rtl/tap_dregs.sv
module tap_dregs
  import tap_pkg::*;
#(
  parameter int          IN_PINS    = 48,
  parameter int          OUT_PINS   = 48,
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h0064,
  parameter logic [10:0] ID_MFR     = 11'h06E,
  parameter logic [31:0] USER_CODE  = 32'hFFFF_FFFF,
  parameter logic [15:0] SIG_CODE   = 16'hFFFF
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                tdi,
  input  tapStrobe_t          strobe,
  input  drSel_e              drSel,
  input  logic                extestOn,
  input  logic                irTdo,
  input  logic [IN_PINS-1:0]  pinIn,
  input  logic [OUT_PINS-1:0] coreOut,
  output logic [OUT_PINS-1:0] pinOut,
  output logic                tdo,
  output logic                tdoEn
);

  localparam int BSR_LEN = IN_PINS + OUT_PINS;
  localparam int ID_W    = 32;
  localparam int USER_W  = 32;
  localparam int SIG_W   = 16;
  localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  logic                bypReg;
  logic [ID_W-1:0]     idSh;
  logic [USER_W-1:0]   userSh;
  logic [SIG_W-1:0]    sigSh;
  logic [BSR_LEN-1:0]  bsrSh;
  logic [OUT_PINS-1:0] updLat;
  logic                drBit;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypReg <= 1'b0;
      idSh   <= '0;
      userSh <= '0;
      sigSh  <= '0;
      bsrSh  <= '0;
      updLat <= '0;
    end else begin
      if (strobe.capDr) begin
        unique case (drSel)
          DR_ID:   idSh   <= ID_WORD;
          DR_USER: userSh <= USER_CODE;
          DR_SIG:  sigSh  <= SIG_CODE;
          DR_BSR:  bsrSh  <= {coreOut, pinIn};
          default: bypReg <= 1'b0;
        endcase
      end else if (strobe.shDr) begin
        unique case (drSel)
          DR_ID:   idSh   <= {tdi, idSh[ID_W-1:1]};
          DR_USER: userSh <= {tdi, userSh[USER_W-1:1]};
          DR_SIG:  sigSh  <= {tdi, sigSh[SIG_W-1:1]};
          DR_BSR:  bsrSh  <= {tdi, bsrSh[BSR_LEN-1:1]};
          default: bypReg <= tdi;
        endcase
      end
      if (strobe.updDr && drSel == DR_BSR)
        updLat <= bsrSh[BSR_LEN-1:IN_PINS];
    end
  end

  always_comb begin
    unique case (drSel)
      DR_ID:   drBit = idSh[0];
      DR_USER: drBit = userSh[0];
      DR_SIG:  drBit = sigSh[0];
      DR_BSR:  drBit = bsrSh[0];
      default: drBit = bypReg;
    endcase
  end

  // serial output launched on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= strobe.shIr ? irTdo : drBit;
      tdoEn <= strobe.shIr | strobe.shDr;
    end
  end

  for (genvar p = 0; p < OUT_PINS; p++) begin : g_outCell
    assign pinOut[p] = extestOn ? updLat[p] : coreOut[p];
  end

  p_tdoen_r2: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (strobe.shDr || strobe.shIr));

  p_byp_cap_r5: assert property (@(posedge tck) disable iff (!trstN)
    (strobe.capDr && drSel == DR_BYP) |=> !bypReg);

  p_latch_hold_r11: assert property (@(posedge tck) disable iff (!trstN)
    !(strobe.updDr && drSel == DR_BSR) |=> $stable(updLat));

endmodule

// File: rtl/jtag_tap_top.sv
module jtag_tap_top
  import tap_pkg::*;
#(
  parameter int          IN_PINS    = 48,
  parameter int          OUT_PINS   = 48,
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h0064,
  parameter logic [10:0] ID_MFR     = 11'h06E,
  parameter logic [31:0] USER_CODE  = 32'hFFFF_FFFF,
  parameter logic [15:0] SIG_CODE   = 16'hFFFF
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                tms,
  input  logic                tdi,
  output logic                tdo,
  output logic                tdoEn,
  input  logic [IN_PINS-1:0]  pinIn,
  input  logic [OUT_PINS-1:0] coreOut,
  output logic [OUT_PINS-1:0] pinOut
);

  tapStrobe_t strobe;
  drSel_e     drSel;
  logic       extestOn;
  logic       irTdo;

  tap_ctrl ctrl_i (
    .tck      (tck),
    .trstN    (trstN),
    .tms      (tms),
    .tdi      (tdi),
    .strobe   (strobe),
    .drSel    (drSel),
    .extestOn (extestOn),
    .irTdo    (irTdo)
  );

  tap_dregs #(
    .IN_PINS    (IN_PINS),
    .OUT_PINS   (OUT_PINS),
    .ID_VERSION (ID_VERSION),
    .ID_PART    (ID_PART),
    .ID_MFR     (ID_MFR),
    .USER_CODE  (USER_CODE),
    .SIG_CODE   (SIG_CODE)
  ) dregs_i (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .strobe   (strobe),
    .drSel    (drSel),
    .extestOn (extestOn),
    .irTdo    (irTdo),
    .pinIn    (pinIn),
    .coreOut  (coreOut),
    .pinOut   (pinOut),
    .tdo      (tdo),
    .tdoEn    (tdoEn)
  );

endmodule

// File: tb/jtag_tap_top_tb_top.sv
module jtag_tap_top_tb_top;

  localparam int IN_P  = 48;
  localparam int OUT_P = 48;
  localparam int BSR   = IN_P + OUT_P;
  localparam logic [3:0]  VER  = 4'h2;
  localparam logic [15:0] PART = 16'hA5C3;
  localparam logic [10:0] MFR  = 11'h06E;
  localparam logic [31:0] UCODE = 32'hCAFE_0123;
  localparam logic [15:0] SCODE = 16'h5A3C;
  localparam logic [31:0] ID_VAL = {VER, PART, MFR, 1'b1};

  // opcode, register length, captured value
  localparam logic [49:0] VEC [6] = '{
    {10'h059, 8'd32, ID_VAL},
    {10'h007, 8'd32, UCODE},
    {10'h079, 8'd16, 16'h0000, SCODE},
    {10'h3FF, 8'd1,  32'h0},
    {10'h123, 8'd1,  32'h0},
    {10'h0F0, 8'd1,  32'h0}
  };

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdoEn;
  logic [IN_P-1:0]  pinIn = '0;
  logic [OUT_P-1:0] coreOut = '0;
  logic [OUT_P-1:0] pinOut;

  int checks = 0;
  int errors = 0;

  always #4 tck = ~tck;

  jtag_tap_top #(
    .IN_PINS(IN_P), .OUT_PINS(OUT_P), .ID_VERSION(VER), .ID_PART(PART),
    .ID_MFR(MFR), .USER_CODE(UCODE), .SIG_CODE(SCODE)
  ) dut_i (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .pinIn(pinIn), .coreOut(coreOut), .pinOut(pinOut)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // from Run-Test/Idle, returns to Run-Test/Idle unless parked in Pause-DR
  task automatic shiftDr(input int n, input logic [127:0] din, input bit park,
                         output logic [127:0] dout, output logic allEn);
    dout = '0;
    allEn = 1'b1;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      allEn &= tdoEn;
      step(i == n - 1, din[i]);
    end
    if (park) step(0, 0);
    else begin step(1, 0); step(0, 0); end
  endtask

  task automatic resumeDr();
    step(1, 0); step(1, 0); step(0, 0);
  endtask

  task automatic shiftIr(input logic [9:0] op, output logic [9:0] cap);
    cap = '0;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 10; i++) begin
      cap[i] = tdo;
      step(i == 9, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic string vecTag(input int k);
    case (k)
      0: return "R6 idcode layout";
      1: return "R7 usercode";
      2: return "R8 signature";
      3: return "R5 bypass length";
      default: return "R4 unassigned opcode to bypass";
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] d;
    logic [127:0] p;
    logic [127:0] q;
    logic [9:0] cap;
    logic en;

    coreOut = 48'h1234_5678_9ABC;
    repeat (3) @(negedge tck);
    #1;
    chk("R2 reset tdoEn low", {127'b0, tdoEn}, 128'b0);
    chk("R10 reset pins follow core", {80'b0, pinOut}, {80'b0, coreOut});
    trstN = 1'b1;
    step(1, 0);
    step(0, 0);
    chk("R2 idle tdoEn low", {127'b0, tdoEn}, 128'b0);

    // reset selects IDCODE; trailing ones prove length 32
    shiftDr(36, {128{1'b1}}, 0, d, en);
    chk("R1 trst selects idcode R6", d, {92'b0, 4'hF, ID_VAL});
    chk("R2 tdoEn high while shifting", {127'b0, en}, 128'd1);

    shiftIr(10'h3FF, cap);
    chk("R3 ir capture pattern", {118'b0, cap}, {118'b0, 10'b00_0000_0001});

    // table of instructions and the register each one selects (R4)
    for (int k = 0; k < 6; k++) begin
      int w;
      logic [127:0] exp;
      w = int'(VEC[k][39:32]);
      shiftIr(VEC[k][49:40], cap);
      shiftDr(w + 4, {128{1'b1}}, 0, d, en);
      exp = ({124'b0, 4'hF} << w) | ({96'b0, VEC[k][31:0]} & ((128'd1 << w) - 128'd1));
      chk(vecTag(k), d, exp);
    end

    // bypass delays tdi by one shift
    shiftIr(10'h3FF, cap);
    shiftDr(8, 128'hB2, 0, d, en);
    chk("R5 bypass one-bit delay", d, {120'b0, 8'h64});

    // TMS reset from a non-default instruction
    shiftIr(10'h007, cap);
    step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    step(0, 0);
    shiftDr(36, {128{1'b1}}, 0, d, en);
    chk("R1 five tms-high edges restore idcode", d, {92'b0, 4'hF, ID_VAL});

    // SAMPLE/PRELOAD
    pinIn = 48'hF0E1_D2C3_B4A5;
    p = {32'b0, 96'h0F1E_2D3C_4B5A_6978_8796_A5B4};
    shiftIr(10'h055, cap);
    shiftDr(BSR, p, 0, d, en);
    chk("R9 sample captures pins and core", d, {32'b0, coreOut, pinIn});
    chk("R9 pins follow core under sample", {80'b0, pinOut}, {80'b0, coreOut});

    // EXTEST drives preloaded pattern
    shiftIr(10'h000, cap);
    chk("R10 extest drives preload", {80'b0, pinOut}, {80'b0, p[95:48]});
    coreOut = 48'h0000_FFFF_0000;
    #1;
    chk("R10 core ignored under extest", {80'b0, pinOut}, {80'b0, p[95:48]});
    pinIn = 48'h1357_9BDF_2468;
    q = {32'b0, 96'hAAAA_5555_CCCC_3333_0F0F_F0F0};
    shiftDr(BSR, q, 1, d, en);
    chk("R10 extest captures input pins", {80'b0, d[47:0]}, {80'b0, pinIn});
    chk("R11 pins hold in pause-dr", {80'b0, pinOut}, {80'b0, p[95:48]});
    resumeDr();
    chk("R11 update-dr loads latch", {80'b0, pinOut}, {80'b0, q[95:48]});

    shiftIr(10'h059, cap);
    chk("R9 pins return to core", {80'b0, pinOut}, {80'b0, coreOut});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule